// File: doc/BRIEF.md
# Target Receive Path with Self-Refilling Holding Register

This block is the byte-level receive side of a serial bus target. Each byte that the bus controller writes enters a small FIFO. From there the oldest byte moves on its own into a single holding register that software reads. A full holding register raises a buffer-full flag. The same level drives a receive interrupt line, which can also serve as a DMA request. When software reads the holding register it is emptied, and the next cycle it is refilled from the FIFO if data is waiting there.

The block keeps two sticky error flags. One is a read-error flag, raised when software reads an empty holding register. The other is an overrun flag, raised when a byte is discarded because the FIFO is full or because the programmed per-transaction write length has been used up. A self-clearing clear request flushes the holding register and the FIFO. For each incoming write request the block also returns an ACK or NACK, decided by an ACK policy input and a one-shot ACK permit.

Three state machines do the work. The holding register has the states HOLD_EMPTY and HOLD_FULL. It goes from HOLD_EMPTY to HOLD_FULL when it loads from a non-empty FIFO, and from HOLD_FULL to HOLD_EMPTY on a software read or a flush. The length limiter has the states XFER_OPEN and XFER_CAPPED. It goes from XFER_OPEN to XFER_CAPPED when the byte count reaches a nonzero limit, and returns to XFER_OPEN at a transaction start. The one-shot permit has the states SHOT_IDLE and SHOT_ARMED. It is armed by a software set and disarmed when it is spent on an ACK under NACK policy.

Top module: `tgt_rx_path`

## Requirements
- R1: When the holding register is empty, no clear is pending and the FIFO holds data, the oldest byte is loaded at the next clock edge. `buf_full` and `rx_irq` rise together at that edge. Bytes leave in arrival order, and a byte pushed at one edge reaches the holding register at the following edge at the earliest.
- R2: A `sw_rd` pulse while `buf_full` is 1 returns `rx_data` and drops `buf_full`/`rx_irq` at the next edge. If the FIFO still holds data, the flags rise again one edge later with the next byte.
- R3: A `sw_rd` pulse while `buf_full` is 0 sets `rd_err` at the next edge, whatever the FIFO fill level.
- R4: The FIFO holds `DEPTH` bytes in addition to the holding register. A byte that arrives while the FIFO is full (judged at the start of the cycle) is discarded and sets `ovf`, once for each such byte.
- R5: A `clr_req` pulse sets `clr_pending` for exactly one cycle. At the end of that cycle the holding register and the FIFO are emptied, so `buf_full` and `rx_irq` read 0. A byte presented during the pending cycle is dropped without setting `ovf`.
- R6: With `max_len` nonzero, only the first `max_len` bytes after `xfer_start` are accepted. Each later byte of the same transaction is discarded and sets `ovf`, even when the FIFO has space. `xfer_start` resets the count.
- R7: With `max_len` equal to 0 no length limit applies.
- R8: `req_ack_valid` pulses one cycle after `xfer_start`. With `ack_policy` at 0, `req_ack` is 1 even when the FIFO is full.
- R9: With `ack_policy` at 1, `req_ack` is 0 unless the one-shot permit (`oneshot_armed`) was 1 when the request arrived.
- R10: `oneshot_set` arms the permit from the next edge. The permit is spent (cleared) by a request that it ACKs under `ack_policy` 1, and is left armed by a request under `ack_policy` 0.
- R11: `rd_err` and `ovf` stay at 1 until a pulse on `rderr_clr` or `ovf_clr` respectively. If a new error and its clear fall in the same cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Pulse: a new private-write request begins |
| ack_policy | input | 1 | 0: ACK every request, 1: NACK unless permitted |
| oneshot_set | input | 1 | Pulse: arm the one-shot ACK permit |
| max_len | input | LEN_W | Per-transaction byte limit, 0 for none |
| byte_valid | input | 1 | Pulse: a received byte is on `byte_data` |
| byte_data | input | DATA_W | Received byte |
| sw_rd | input | 1 | Pulse: software reads the holding register |
| clr_req | input | 1 | Pulse: request a buffer clear |
| rderr_clr | input | 1 | Pulse: write-1-to-clear for `rd_err` |
| ovf_clr | input | 1 | Pulse: write-1-to-clear for `ovf` |
| rx_data | output | DATA_W | Holding register contents |
| buf_full | output | 1 | Holding register holds a byte |
| rx_irq | output | 1 | Receive interrupt / DMA request |
| rd_err | output | 1 | Sticky read-while-empty flag |
| ovf | output | 1 | Sticky overrun flag |
| clr_pending | output | 1 | Clear bit, self-clearing after one cycle |
| oneshot_armed | output | 1 | One-shot ACK permit is armed |
| req_ack_valid | output | 1 | ACK decision is valid this cycle |
| req_ack | output | 1 | 1 = ACK, 0 = NACK |

## Verification
A detected read error and the software clear of `rd_err` can fall in the same cycle. The bench provokes this by pulsing `sw_rd` on an empty holding register together with `rderr_clr`, and it expects the flag to remain 1 afterwards. The same collision is run for `ovf` by sending a byte into a full FIFO while `ovf_clr` is pulsed. A software read and a FIFO refill also meet in one cycle on a nearly full path. There the bench expects the flag to dip for one cycle and the bytes to come out in order.

// File: rtl/tgt_rx_pkg.sv
package tgt_rx_pkg;

    typedef enum logic {
        HOLD_EMPTY,
        HOLD_FULL
    } hold_state_e;

    typedef enum logic {
        XFER_OPEN,
        XFER_CAPPED
    } xfer_state_e;

    typedef enum logic {
        SHOT_IDLE,
        SHOT_ARMED
    } shot_state_e;

endpackage

// File: rtl/tgt_rx_fifo.sv
module tgt_rx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic              full,
    output logic              empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]     count_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign full     = (count_q == CW'(DEPTH));
    assign empty    = (count_q == '0);
    assign pop_data = mem[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[wr_ptr_q] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else if (flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= bump(wr_ptr_q);
            if (pop)  rd_ptr_q <= bump(rd_ptr_q);
            unique case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end
endmodule

// File: rtl/tgt_rx_hold.sv
module tgt_rx_hold
    import tgt_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              sw_rd,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full,
    output logic              rd_err_hit
);
    hold_state_e       state_q, state_d;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HOLD_EMPTY;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (fifo_pop) data_q <= fifo_data;
        end
    end

    always_comb begin
        state_d    = state_q;
        fifo_pop   = 1'b0;
        rd_err_hit = 1'b0;
        unique case (state_q)
            HOLD_EMPTY: begin
                rd_err_hit = sw_rd;
                if (!flush && !fifo_empty) begin
                    fifo_pop = 1'b1;
                    state_d  = HOLD_FULL;
                end
            end
            HOLD_FULL: begin
                if (flush || sw_rd) state_d = HOLD_EMPTY;
            end
        endcase
    end

    assign hold_full = (state_q == HOLD_FULL);
    assign hold_data = data_q;
endmodule

// File: rtl/tgt_rx_limit.sv
module tgt_rx_limit
    import tgt_rx_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_start,
    input  logic             byte_in,
    input  logic [LEN_W-1:0] max_len,
    output logic             over_len
);
    xfer_state_e      state_q, state_d, state_base;
    logic [LEN_W-1:0] cnt_q, cnt_d, cnt_base, cnt_inc;
    logic             limit_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XFER_OPEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        limit_on   = (max_len != '0);
        state_base = xfer_start ? XFER_OPEN : state_q;
        cnt_base   = xfer_start ? '0 : cnt_q;
        cnt_inc    = (cnt_base == '1) ? cnt_base : cnt_base + 1'b1;
        state_d    = state_base;
        cnt_d      = cnt_base;
        over_len   = 1'b0;
        unique case (state_base)
            XFER_OPEN: begin
                if (byte_in) begin
                    cnt_d = cnt_inc;
                    if (limit_on && (cnt_inc >= max_len)) state_d = XFER_CAPPED;
                end
            end
            XFER_CAPPED: begin
                over_len = byte_in;
            end
        endcase
    end
endmodule

// File: rtl/tgt_rx_ack.sv
module tgt_rx_ack
    import tgt_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_start,
    input  logic ack_policy,
    input  logic oneshot_set,
    output logic ack_valid,
    output logic ack,
    output logic armed
);
    shot_state_e state_q, state_d;
    logic        grant, spend;
    logic        ack_valid_q, ack_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= SHOT_IDLE;
            ack_valid_q <= 1'b0;
            ack_q       <= 1'b0;
        end else begin
            state_q     <= state_d;
            ack_valid_q <= xfer_start;
            ack_q       <= xfer_start && grant;
        end
    end

    always_comb begin
        grant   = !ack_policy || (state_q == SHOT_ARMED);
        spend   = xfer_start && ack_policy && (state_q == SHOT_ARMED);
        state_d = state_q;
        unique case (state_q)
            SHOT_IDLE:  if (oneshot_set) state_d = SHOT_ARMED;
            SHOT_ARMED: if (spend && !oneshot_set) state_d = SHOT_IDLE;
        endcase
    end

    assign ack_valid = ack_valid_q;
    assign ack       = ack_q;
    assign armed     = (state_q == SHOT_ARMED);
endmodule

// File: rtl/tgt_rx_path.sv
module tgt_rx_path #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              ack_policy,
    input  logic              oneshot_set,
    input  logic [LEN_W-1:0]  max_len,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              sw_rd,
    input  logic              clr_req,
    input  logic              rderr_clr,
    input  logic              ovf_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              buf_full,
    output logic              rx_irq,
    output logic              rd_err,
    output logic              ovf,
    output logic              clr_pending,
    output logic              oneshot_armed,
    output logic              req_ack_valid,
    output logic              req_ack
);
    logic              clr_q, rd_err_q, ovf_q;
    logic              byte_live, over_len, push, ovf_hit;
    logic              fifo_full, fifo_empty, fifo_pop, rd_err_hit;
    logic [DATA_W-1:0] fifo_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_q    <= 1'b0;
            rd_err_q <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            clr_q    <= clr_req;
            rd_err_q <= rd_err_hit || (rd_err_q && !rderr_clr);
            ovf_q    <= ovf_hit    || (ovf_q    && !ovf_clr);
        end
    end

    always_comb begin
        byte_live = byte_valid && !clr_q;
        push      = byte_live && !over_len && !fifo_full;
        ovf_hit   = byte_live && (over_len || fifo_full);
    end

    tgt_rx_limit #(.LEN_W(LEN_W)) u_limit (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_start (xfer_start),
        .byte_in    (byte_live),
        .max_len    (max_len),
        .over_len   (over_len)
    );

    tgt_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (clr_q),
        .push      (push),
        .push_data (byte_data),
        .pop       (fifo_pop),
        .pop_data  (fifo_data),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    tgt_rx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (clr_q),
        .sw_rd      (sw_rd),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .fifo_pop   (fifo_pop),
        .hold_data  (rx_data),
        .hold_full  (buf_full),
        .rd_err_hit (rd_err_hit)
    );

    tgt_rx_ack u_ack (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_start  (xfer_start),
        .ack_policy  (ack_policy),
        .oneshot_set (oneshot_set),
        .ack_valid   (req_ack_valid),
        .ack         (req_ack),
        .armed       (oneshot_armed)
    );

    assign rx_irq      = buf_full;
    assign rd_err      = rd_err_q;
    assign ovf         = ovf_q;
    assign clr_pending = clr_q;
endmodule

// File: rtl/tgt_rx_path_chk.sv
module tgt_rx_path_chk (
    input logic clk,
    input logic rst_n,
    input logic xfer_start,
    input logic ack_policy,
    input logic oneshot_set,
    input logic byte_valid,
    input logic sw_rd,
    input logic rderr_clr,
    input logic ovf_clr,
    input logic buf_full,
    input logic rd_err,
    input logic ovf,
    input logic clr_pending,
    input logic oneshot_armed,
    input logic req_ack_valid,
    input logic req_ack,
    input logic fifo_full,
    input logic fifo_empty
);
    a_r1_refill: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_full && !fifo_empty && !clr_pending) |=> buf_full);

    a_r2_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rd && buf_full) |=> !buf_full);

    a_r3_read_error: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rd && !buf_full) |=> rd_err);

    a_r4_overrun_full: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && fifo_full && !clr_pending) |=> ovf);

    a_r5_clear_once: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pending |=> (!clr_pending && !buf_full));

    a_r8_ack_policy0: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && !ack_policy) |=> (req_ack_valid && req_ack));

    a_r9_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && ack_policy && !oneshot_armed) |=> (req_ack_valid && !req_ack));

    a_r10_spend: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && ack_policy && oneshot_armed && !oneshot_set) |=> !oneshot_armed);

    a_r11_rderr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_err && !rderr_clr) |=> rd_err);

    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);
endmodule

bind tgt_rx_path tgt_rx_path_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .xfer_start    (xfer_start),
    .ack_policy    (ack_policy),
    .oneshot_set   (oneshot_set),
    .byte_valid    (byte_valid),
    .sw_rd         (sw_rd),
    .rderr_clr     (rderr_clr),
    .ovf_clr       (ovf_clr),
    .buf_full      (buf_full),
    .rd_err        (rd_err),
    .ovf           (ovf),
    .clr_pending   (clr_pending),
    .oneshot_armed (oneshot_armed),
    .req_ack_valid (req_ack_valid),
    .req_ack       (req_ack),
    .fifo_full     (fifo_full),
    .fifo_empty    (fifo_empty)
);

// File: tb/tgt_rx_path_bench.sv
module tgt_rx_path_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 4;
    localparam int LEN_W  = 8;

    // ACK table fields: {ack_policy, arm one-shot first, expected req_ack, expected armed after}
    localparam logic [3:0] ACK_VEC [5] = '{4'b0010, 4'b1000, 4'b1110, 4'b0111, 4'b1010};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              xfer_start = 1'b0, ack_policy = 1'b0, oneshot_set = 1'b0;
    logic [LEN_W-1:0]  max_len = '0;
    logic              byte_valid = 1'b0;
    logic [DATA_W-1:0] byte_data = '0;
    logic              sw_rd = 1'b0, clr_req = 1'b0, rderr_clr = 1'b0, ovf_clr = 1'b0;
    logic [DATA_W-1:0] rx_data;
    logic              buf_full, rx_irq, rd_err, ovf, clr_pending;
    logic              oneshot_armed, req_ack_valid, req_ack;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tgt_rx_path #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_tgt_rx_path (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .ack_policy(ack_policy),
        .oneshot_set(oneshot_set), .max_len(max_len), .byte_valid(byte_valid),
        .byte_data(byte_data), .sw_rd(sw_rd), .clr_req(clr_req), .rderr_clr(rderr_clr),
        .ovf_clr(ovf_clr), .rx_data(rx_data), .buf_full(buf_full), .rx_irq(rx_irq),
        .rd_err(rd_err), .ovf(ovf), .clr_pending(clr_pending),
        .oneshot_armed(oneshot_armed), .req_ack_valid(req_ack_valid), .req_ack(req_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [DATA_W-1:0] d);
        byte_valid = 1'b1; byte_data = d;
        step();
        byte_valid = 1'b0;
    endtask

    task automatic rd_pulse();
        sw_rd = 1'b1;
        step();
        sw_rd = 1'b0;
    endtask

    task automatic start_xfer();
        xfer_start = 1'b1;
        step();
        xfer_start = 1'b0;
    endtask

    task automatic clr_ovf();
        ovf_clr = 1'b1;
        step();
        ovf_clr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset buf_full", buf_full, 0);
        chk("reset rx_irq", rx_irq, 0);
        chk("reset rd_err", rd_err, 0);
        chk("reset ovf", ovf, 0);
        chk("reset req_ack_valid", req_ack_valid, 0);
        chk("reset clr_pending", clr_pending, 0);

        // R8 R9 R10: table of ACK decisions
        for (int i = 0; i < 5; i++) begin
            logic [3:0] v;
            v = ACK_VEC[i];
            ack_policy = v[3];
            if (v[2]) begin
                oneshot_set = 1'b1;
                step();
                oneshot_set = 1'b0;
                chk("R10 armed after set", oneshot_armed, 1);
            end
            start_xfer();
            chk("R8 req_ack_valid pulse", req_ack_valid, 1);
            chk("R9 req_ack decision", req_ack, v[1]);
            chk("R10 permit after request", oneshot_armed, v[0]);
        end
        ack_policy = 1'b0;
        step();
        chk("R8 req_ack_valid one cycle", req_ack_valid, 0);

        // R1 latency and R2 read
        push(8'hA5);
        chk("R1 not yet loaded", buf_full, 0);
        step();
        chk("R1 buf_full", buf_full, 1);
        chk("R1 rx_irq", rx_irq, 1);
        chk("R1 data", rx_data, 8'hA5);
        rd_pulse();
        chk("R2 cleared by read", buf_full, 0);
        chk("R2 irq cleared", rx_irq, 0);

        // R3 and R11
        rd_pulse();
        chk("R3 read error", rd_err, 1);
        step();
        chk("R11 rd_err sticky", rd_err, 1);
        rderr_clr = 1'b1; step(); rderr_clr = 1'b0;
        chk("R11 rd_err cleared", rd_err, 0);
        sw_rd = 1'b1; rderr_clr = 1'b1; step(); sw_rd = 1'b0; rderr_clr = 1'b0;
        chk("R11 set wins over clear", rd_err, 1);
        rderr_clr = 1'b1; step(); rderr_clr = 1'b0;

        // R4, R7: fill with no length limit
        max_len = '0;
        start_xfer();
        for (int i = 0; i < 5; i++) push(8'(8'h10 + i));
        chk("R7 no limit, no overrun", ovf, 0);
        push(8'h15);
        chk("R4 overrun on full", ovf, 1);
        start_xfer();
        chk("R8 ack while full", req_ack, 1);
        ovf_clr = 1'b1; byte_valid = 1'b1; byte_data = 8'h16;
        step();
        ovf_clr = 1'b0; byte_valid = 1'b0;
        chk("R11 ovf set wins over clear", ovf, 1);
        clr_ovf();
        chk("R11 ovf cleared", ovf, 0);
        for (int i = 0; i < 5; i++) begin
            chk("R2 full before read", buf_full, 1);
            chk("R1 order", rx_data, 8'(8'h10 + i));
            rd_pulse();
            chk("R2 dip after read", buf_full, 0);
            step();
        end
        chk("R2 drained", buf_full, 0);

        // R6: length limit
        max_len = 8'd2;
        start_xfer();
        push(8'h21);
        push(8'h22);
        chk("R6 within limit", ovf, 0);
        push(8'h23);
        chk("R6 overrun past limit", ovf, 1);
        chk("R6 first byte", rx_data, 8'h21);
        rd_pulse(); step();
        chk("R6 second byte", rx_data, 8'h22);
        rd_pulse(); step();
        chk("R6 third byte dropped", buf_full, 0);
        clr_ovf();
        start_xfer();
        push(8'h31);
        chk("R6 count reset at start", ovf, 0);
        step();
        chk("R6 new transaction data", rx_data, 8'h31);
        rd_pulse();
        max_len = '0;

        // R5: clear flushes holding register and FIFO
        push(8'h41); push(8'h42); push(8'h43);
        chk("R5 full before clear", buf_full, 1);
        clr_req = 1'b1; step(); clr_req = 1'b0;
        chk("R5 clr_pending", clr_pending, 1);
        byte_valid = 1'b1; byte_data = 8'h44;
        step();
        byte_valid = 1'b0;
        chk("R5 clr self-clears", clr_pending, 0);
        chk("R5 buf_full cleared", buf_full, 0);
        chk("R5 rx_irq cleared", rx_irq, 0);
        step(); step();
        chk("R5 fifo flushed", buf_full, 0);
        chk("R5 no overrun on dropped byte", ovf, 0);
        rd_pulse();
        chk("R5 read after clear errors", rd_err, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule